// File: doc/BRIEF.md
# Same-Location Busy Arbiter for a Two-Port Memory

This block sits beside a memory array that two independent ports share. Each clock cycle it compares the two ports' addresses. When both ports are enabled and point at the same word, it marks one port as busy. It also closes that port's write path so that the losing write never reaches the array. The rule is first come, first served. A port whose enable and address were already present in the previous cycle beats a port that has just arrived. When both arrive in the same cycle, the left port wins.

The decision is made only from the enables and the addresses. Read and write requests play no part in it. The winner is kept in a three-state machine until the conflict clears, which happens when the addresses differ or when either enable drops. Busy outputs and write gates follow the current inputs combinationally, so the losing side is blocked in the same cycle the match appears. Reads are never delayed; the busy flag only tells the losing port that its data may be stale.

States of the machine: `ST_FREE` (no conflict held), `ST_LEFT_OWNS` (left won, right is busy), `ST_RIGHT_OWNS` (right won, left is busy). Transitions: `FREE->LEFT_OWNS` on a new match where the left port was settled and the right was not, or on a same-cycle arrival; `FREE->RIGHT_OWNS` on a new match where the right port was settled and the left was not; `LEFT_OWNS->FREE` and `RIGHT_OWNS->FREE` when the match ends; every other case holds the current state.

Top module: `busy_arb`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both busy outputs are high (1 = not busy) and both write gates are low. No winner is held.
- R2: When the addresses differ, or either enable is low, both busy outputs are high.
- R3: The write request inputs have no influence on the busy outputs. A conflict between two reads is arbitrated exactly like one involving writes.
- R4: If the left port's enable and address are unchanged from the previous cycle and the right port newly creates a match, the right busy output goes low in that same cycle.
- R5: If the right port's enable and address are unchanged from the previous cycle and the left port newly creates a match, the left busy output goes low in that same cycle.
- R6: If both ports change in the cycle a match first appears, the left port wins and the right busy output goes low.
- R7: The two busy outputs are never low together.
- R8: A port's write gate is high exactly when its enable and write request are high and its busy output is high.
- R9: Once a winner is chosen, the same port stays busy on every following cycle in which the match persists. This holds even if both ports move to a new shared address together.
- R10: Busy is released in the cycle the match ends. The next match is arbitrated afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | ADDR_W (11) | Left port word address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | ADDR_W (11) | Right port word address |
| r_wr | input | 1 | Right port write request |
| l_busy_n | output | 1 | Left busy, active low |
| r_busy_n | output | 1 | Right busy, active low |
| l_wr_ok | output | 1 | Left write allowed into the array |
| r_wr_ok | output | 1 | Right write allowed into the array |

## Verification
The hardest condition to reach is a conflict that persists while the winner is already held. The addresses of both ports move together to a new shared location, so no cycle without a match separates them. The stimulus sets up a same-cycle tie and then moves both ports to a second common address in one step. It expects the right port to stay busy, because no new decision is taken. A second hard case is re-arbitration straight after a release: one port steps off the shared word for a single cycle and steps back, and the settled partner must win again.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;
    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_LEFT_OWNS  = 2'd1,
        ST_RIGHT_OWNS = 2'd2
    } arb_state_t;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned LEFT_IDX  = 0;
    localparam int unsigned RIGHT_IDX = 1;
endpackage

// File: rtl/slot_watch.sv
// Remembers one port's enable and address from the previous cycle and
// reports whether the port is "new" (its request differs from last cycle).
module slot_watch #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_new
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    always_comb begin
        is_new = (en != en_q) || (en && (addr != addr_q));
    end
endmodule

// File: rtl/addr_match.sv
// Contention detector: both ports enabled on the same word.
module addr_match #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              a_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              hit
);
    always_comb begin
        hit = a_en && b_en && (a_addr == b_addr);
    end
endmodule

// File: rtl/arb_fsm.sv
// Holds the winner of a conflict and names the losing side.
module arb_fsm
    import busy_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       left_new,
    input  logic       right_new,
    output logic       left_loses,
    output logic       right_loses,
    output arb_state_t state
);
    arb_state_t state_nx;
    logic       right_first;

    always_comb begin
        right_first = left_new && !right_new;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FREE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx    = state;
        left_loses  = 1'b0;
        right_loses = 1'b0;
        unique case (state)
            ST_FREE: begin
                if (hit) begin
                    if (right_first) begin
                        left_loses = 1'b1;
                        state_nx   = ST_RIGHT_OWNS;
                    end else begin
                        right_loses = 1'b1;
                        state_nx    = ST_LEFT_OWNS;
                    end
                end
            end
            ST_LEFT_OWNS: begin
                if (hit) begin
                    right_loses = 1'b1;
                end else begin
                    state_nx = ST_FREE;
                end
            end
            ST_RIGHT_OWNS: begin
                if (hit) begin
                    left_loses = 1'b1;
                end else begin
                    state_nx = ST_FREE;
                end
            end
            default: begin
                state_nx = ST_FREE;
            end
        endcase
    end
endmodule

// File: rtl/busy_arb.sv
module busy_arb
    import busy_arb_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    logic [NUM_PORTS-1:0] en_v;
    logic [NUM_PORTS-1:0] wr_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    logic [NUM_PORTS-1:0] new_v;
    logic [NUM_PORTS-1:0] lose_v;
    logic [NUM_PORTS-1:0] busy_nv;
    logic [NUM_PORTS-1:0] wr_ok_v;
    logic                 hit;
    arb_state_t           state;

    always_comb begin
        en_v[LEFT_IDX]    = l_en;
        en_v[RIGHT_IDX]   = r_en;
        wr_v[LEFT_IDX]    = l_wr;
        wr_v[RIGHT_IDX]   = r_wr;
        addr_v[LEFT_IDX]  = l_addr;
        addr_v[RIGHT_IDX] = r_addr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        slot_watch #(.ADDR_W(ADDR_W)) u_watch (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_v[p]),
            .addr   (addr_v[p]),
            .is_new (new_v[p])
        );

        always_comb begin
            busy_nv[p] = !rst_n || !lose_v[p];
            wr_ok_v[p] = rst_n && en_v[p] && wr_v[p] && busy_nv[p];
        end
    end

    addr_match #(.ADDR_W(ADDR_W)) u_match (
        .a_en   (l_en),
        .a_addr (l_addr),
        .b_en   (r_en),
        .b_addr (r_addr),
        .hit    (hit)
    );

    arb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .left_new    (new_v[LEFT_IDX]),
        .right_new   (new_v[RIGHT_IDX]),
        .left_loses  (lose_v[LEFT_IDX]),
        .right_loses (lose_v[RIGHT_IDX]),
        .state       (state)
    );

    always_comb begin
        l_busy_n = busy_nv[LEFT_IDX];
        r_busy_n = busy_nv[RIGHT_IDX];
        l_wr_ok  = wr_ok_v[LEFT_IDX];
        r_wr_ok  = wr_ok_v[RIGHT_IDX];
    end
endmodule

// File: rtl/busy_arb_checker.sv
module busy_arb_checker #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_wr,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_wr,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_ok,
    input logic              r_wr_ok
);
    logic same_word;
    always_comb same_word = l_en && r_en && (l_addr == r_addr);

    a_r7_never_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    a_r2_no_conflict_free: assert property (@(posedge clk) disable iff (!rst_n)
        !same_word |-> (l_busy_n && r_busy_n));

    a_r8_left_gate: assert property (@(posedge clk) disable iff (!rst_n)
        l_wr_ok |-> (l_en && l_wr && l_busy_n));

    a_r8_right_gate: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr_ok |-> (r_en && r_wr && r_busy_n));

    a_r9_right_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && same_word) |=> (!same_word || !r_busy_n));

    a_r9_left_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && same_word) |=> (!same_word || !l_busy_n));

    a_r4_settled_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(l_en && !same_word) && same_word && $stable(l_en) && $stable(l_addr))
        |-> !r_busy_n);

    a_r5_settled_right_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_en && !same_word) && same_word && $stable(r_en) && $stable(r_addr))
        |-> !l_busy_n);
endmodule

bind busy_arb busy_arb_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_en     (l_en),
    .l_addr   (l_addr),
    .l_wr     (l_wr),
    .r_en     (r_en),
    .r_addr   (r_addr),
    .r_wr     (r_wr),
    .l_busy_n (l_busy_n),
    .r_busy_n (r_busy_n),
    .l_wr_ok  (l_wr_ok),
    .r_wr_ok  (r_wr_ok)
);

// File: tb/test_busy_arb.sv
module test_busy_arb;
    localparam int unsigned ADDR_W = 11;
    localparam time         PERIOD = 10ns;

    typedef struct {
        logic  lb;
        logic  rb;
        logic  lok;
        logic  rok;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic              l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;
    exp_t sb [$];

    always #(PERIOD/2) clk = ~clk;

    busy_arb #(.ADDR_W(ADDR_W)) i_busy_arb (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // driver: apply one vector at the falling edge, queue the expectation
    task automatic drive(input logic le, input logic [ADDR_W-1:0] la, input logic lw,
                         input logic re, input logic [ADDR_W-1:0] ra, input logic rw,
                         input logic elb, input logic erb, input string tag);
        exp_t e;
        @(negedge clk);
        l_en = le; l_addr = la; l_wr = lw;
        r_en = re; r_addr = ra; r_wr = rw;
        e.lb  = elb;
        e.rb  = erb;
        e.lok = le && lw && elb;   // R8
        e.rok = re && rw && erb;   // R8
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare a little after the falling edge, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if ({l_busy_n, r_busy_n, l_wr_ok, r_wr_ok} !== {e.lb, e.rb, e.lok, e.rok}) begin
                    n_fail++;
                    $display("FAIL %s: got busy_n l/r=%b%b wr_ok l/r=%b%b, expected %b%b %b%b",
                             e.tag, l_busy_n, r_busy_n, l_wr_ok, r_wr_ok,
                             e.lb, e.rb, e.lok, e.rok);
                end
                n_checks++;
                if (!l_busy_n && !r_busy_n) begin
                    n_fail++;
                    $display("FAIL R7: got busy_n l/r=%b%b, expected not 00", l_busy_n, r_busy_n);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: got run still active, expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs during reset, with the two ports already matching
        l_en = 1'b1; r_en = 1'b1; l_wr = 1'b1; r_wr = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        n_checks++;
        if ({l_busy_n, r_busy_n, l_wr_ok, r_wr_ok} !== 4'b1100) begin
            n_fail++;
            $display("FAIL R1: got %b%b%b%b, expected 1100", l_busy_n, r_busy_n, l_wr_ok, r_wr_ok);
        end
        l_en = 1'b0; r_en = 1'b0; l_wr = 1'b0; r_wr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 11'h000, 0, 0, 11'h000, 0, 1, 1, "R1 after reset");

        drive(1, 11'h005, 1, 0, 11'h005, 1, 1, 1, "R2 right disabled");
        drive(1, 11'h005, 1, 1, 11'h006, 1, 1, 1, "R2 addresses differ");
        drive(1, 11'h005, 1, 1, 11'h005, 1, 1, 0, "R4 right arrives, right write gated R8");
        drive(1, 11'h005, 1, 1, 11'h005, 1, 1, 0, "R9 hold right busy");
        drive(1, 11'h005, 0, 1, 11'h005, 0, 1, 0, "R3 write requests dropped, busy unchanged");
        drive(1, 11'h005, 1, 1, 11'h007, 1, 1, 1, "R10 release on mismatch");
        drive(1, 11'h005, 1, 1, 11'h005, 1, 1, 0, "R10 re-arbitrated, left settled wins");
        drive(0, 11'h005, 1, 1, 11'h005, 1, 1, 1, "R10 release on left disable");
        drive(1, 11'h005, 1, 1, 11'h005, 1, 0, 1, "R5 left arrives, left write gated R8");
        drive(1, 11'h005, 1, 1, 11'h005, 0, 0, 1, "R9 hold left busy");
        drive(0, 11'h005, 0, 0, 11'h005, 0, 1, 1, "R2 both disabled");
        drive(1, 11'h7FF, 0, 1, 11'h7FF, 0, 1, 0, "R6 tie on reads, left wins R3");
        drive(1, 11'h123, 1, 1, 11'h123, 1, 1, 0, "R9 both move together, winner kept");
        drive(1, 11'h123, 1, 0, 11'h123, 1, 1, 1, "R10 release on right disable");
        drive(1, 11'h200, 1, 1, 11'h200, 1, 1, 0, "R6 tie with writes, left wins");
        drive(0, 11'h200, 0, 0, 11'h200, 0, 1, 1, "R2 idle");
        drive(0, 11'h300, 0, 1, 11'h300, 0, 1, 1, "R2 only right enabled");
        drive(1, 11'h300, 0, 1, 11'h300, 1, 0, 1, "R5 read arrives on left against settled right R3");
        drive(1, 11'h300, 1, 1, 11'h300, 1, 0, 1, "R8 busy left write blocked");

        @(negedge clk);
        #2;
        finish_run();
    end
endmodule